// File: doc/BRIEF.md
# Serial Memory Read Target on a Two-Wire Bus

This block is a bus target that answers on a two-wire I2C bus and serves bytes from an internal, byte-wide, read-only store. A fast system clock oversamples the clock line and the data line. The block pulls the data line low through an open-drain enable and never drives it high. START, repeated START and STOP are recognised from the oversampled lines. A persistent address counter decides which byte is sent next.

A controller can read in three ways. The first is a current-address read, which continues from wherever the counter stands. The second is a random read: a write transfer carries a two-byte address, and a repeated START then turns the transfer into a read. The third is a sequential read, in which the controller acknowledges each byte to receive the next one. The counter keeps its value across transactions and wraps from the last location to zero. Bytes written after the address are acknowledged and then dropped, because the store cannot be programmed from the bus.

The store is filled at elaboration from a fixed formula. A bench can therefore predict every byte without loading any file. The store depth is a parameter; only the low address bits that the depth needs are kept.

Top module: `i2c_rd_target`

## Requirements
- R1: After reset the data-line enable is 0. The address counter is 0, so the first current-address read returns the byte at location 0.
- R2: START is detected as a falling data line while the clock line is high. STOP is detected as a rising data line while the clock line is high. Both are detected on the lines after a two-stage synchroniser, and every transaction begins with a START.
- R3: A first byte after START whose upper seven bits equal the target address and whose bit 0 is 1 is acknowledged by pulling the data line low during the 9th clock. The target then sends the byte at the counter address, MSB first. The byte at location a is ((a*29 + SEED) mod 256) XOR (floor(a/256) mod 256).
- R4: A first byte whose upper seven bits differ from the target address gets no acknowledge. The data line stays released until the next START, even if more clocks or an address byte arrive without a new START.
- R5: A first byte with a matching address and bit 0 equal to 0 is acknowledged. The two bytes that follow are each acknowledged: the high address byte first, then the low address byte. When the low byte has been received, the counter is loaded with the low MEM_AW bits of the 16-bit address. A repeated START with a read request then sends from that address.
- R6: Each byte that the controller acknowledges is followed by the next sequential byte.
- R7: A not-acknowledge from the controller ends the transfer: the data line is released, and a following STOP leaves it released.
- R8: The counter advances by one as each sent byte's acknowledge bit is sampled, and it is otherwise held, also between transactions. A current-address read therefore starts one past the last byte sent.
- R9: Advancing from location 2^MEM_AW-1 gives location 0, both inside a sequential read and for the next transaction.
- R10: Data bytes that follow the two address bytes of a write are acknowledged and discarded. The counter keeps the loaded address.
- R11: The data-line enable changes only while the clock line is low. It is stable while the clock line is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The bench builds the block with MEM_AW = 6, which gives a 64-byte store, and with SEED = 8'h5A and the default target address 7'h50. The small depth puts the last location only a few bytes from any start point. Wrap-around can therefore be reached inside one sequential read, at the end of a single-byte read, and through a 16-bit address whose upper bits are discarded. The address 7'h23 serves as the non-matching target.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_TX_NEXT
  } fsm_st_t;

  typedef enum logic [1:0] {
    BK_DEV,
    BK_AHI,
    BK_ALO,
    BK_DATA
  } byte_kind_t;

  // preload pattern of the store
  function automatic logic [7:0] fill_byte(input logic [15:0] a, input logic [7:0] seed);
    logic [7:0] mix;
    mix = a[7:0] * 8'd29 + seed;
    return mix ^ a[15:8];
  endfunction

  // counter step with wrap at 2^aw
  function automatic logic [15:0] wrap_inc(input logic [15:0] a, input int unsigned aw);
    logic [15:0] mask;
    mask = (16'd1 << aw) - 16'd1;
    return (a + 16'd1) & mask;
  endfunction

  function automatic logic addr_match(input logic [7:0] b, input logic [6:0] tgt);
    return b[7:1] == tgt;
  endfunction

endpackage

// File: rtl/i2c_rd_sync.sv
module i2c_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic scl_prev,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LINES = 2;

  logic [LINES-1:0] pin_in;
  logic [STAGES:0]  pipe [LINES];

  assign pin_in = {sda_i, scl_i};

  // one synchroniser chain per line, plus one history flop
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= '1;
      else        pipe[g] <= {pipe[g][STAGES-1:0], pin_in[g]};
    end
  end

  logic sda_prev;

  assign scl_q    = pipe[0][STAGES-1];
  assign scl_prev = pipe[0][STAGES];
  assign sda_q    = pipe[1][STAGES-1];
  assign sda_prev = pipe[1][STAGES];

  assign scl_rise  = scl_q & ~scl_prev;
  assign scl_fall  = ~scl_q & scl_prev;
  assign start_det = scl_q & scl_prev & sda_prev & ~sda_q;
  assign stop_det  = scl_q & scl_prev & ~sda_prev & sda_q;

endmodule

// File: rtl/i2c_rd_rom.sv
module i2c_rd_rom
  import i2c_rd_pkg::*;
#(
  parameter int         AW   = 10,
  parameter logic [7:0] SEED = 8'h3C
) (
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    assign rom[i] = fill_byte(16'(i), SEED);
  end

  assign rdata = rom[raddr];

endmodule

// File: rtl/i2c_rd_addr_ctr.sv
module i2c_rd_addr_ctr
  import i2c_rd_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] cnt
);

  logic [AW-1:0] cnt_next;

  assign cnt_next = AW'(wrap_inc(16'(cnt), AW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (adv)  cnt <= cnt_next;
  end

endmodule

// File: rtl/i2c_rd_fsm.sv
module i2c_rd_fsm
  import i2c_rd_pkg::*;
#(
  parameter int         AW       = 10,
  parameter logic [6:0] TGT_ADDR = 7'h50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_q,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          cnt_adv,
  output logic          cnt_load,
  output logic [AW-1:0] load_val,
  output logic          dev_hit,
  output logic          addr_miss
);

  localparam logic [3:0] BITS = 4'd8;

  fsm_st_t    st;
  byte_kind_t kind;
  logic [3:0] bitcnt;
  logic [7:0] rx_sh;
  logic [7:0] tx_sh;
  logic [7:0] ahi;
  logic       rw;
  logic       no_evt;
  logic       rx_done;

  assign no_evt  = ~start_det & ~stop_det;
  assign rx_done = no_evt & (st == ST_RX) & scl_fall & (bitcnt == BITS);

  assign dev_hit   = rx_done & (kind == BK_DEV) &  addr_match(rx_sh, TGT_ADDR);
  assign addr_miss = rx_done & (kind == BK_DEV) & ~addr_match(rx_sh, TGT_ADDR);
  assign cnt_load  = rx_done & (kind == BK_ALO);
  assign cnt_adv   = no_evt & (st == ST_TX_ACK) & scl_rise;
  assign load_val  = AW'({ahi, rx_sh});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      kind   <= BK_DEV;
      bitcnt <= '0;
      rx_sh  <= '0;
      tx_sh  <= '0;
      ahi    <= '0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      st     <= ST_RX;
      kind   <= BK_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise && bitcnt != BITS) begin
            rx_sh  <= {rx_sh[6:0], sda_q};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == BITS) begin
            bitcnt <= '0;
            if (kind == BK_DEV && !addr_match(rx_sh, TGT_ADDR)) begin
              st <= ST_IDLE;
            end else begin
              sda_oe <= 1'b1;
              st     <= ST_RX_ACK;
              if (kind == BK_DEV) rw  <= rx_sh[0];
              if (kind == BK_AHI) ahi <= rx_sh;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            if (kind == BK_DEV && rw) begin
              st     <= ST_TX;
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              st     <= ST_RX;
              sda_oe <= 1'b0;
              case (kind)
                BK_DEV:  kind <= BK_AHI;
                BK_AHI:  kind <= BK_ALO;
                default: kind <= BK_DATA;
              endcase
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == BITS - 4'd1) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              st     <= ST_TX_ACK;
            end else begin
              tx_sh  <= {tx_sh[6:0], 1'b0};
              sda_oe <= ~tx_sh[6];
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) st <= sda_q ? ST_IDLE : ST_TX_NEXT;
        end
        ST_TX_NEXT: begin
          if (scl_fall) begin
            st     <= ST_TX;
            tx_sh  <= rd_data;
            sda_oe <= ~rd_data[7];
            bitcnt <= '0;
          end
        end
        default: begin
          st     <= ST_IDLE;
          sda_oe <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/i2c_rd_target.sv
module i2c_rd_target
  import i2c_rd_pkg::*;
#(
  parameter int         MEM_AW      = 10,
  parameter logic [6:0] TGT_ADDR    = 7'h50,
  parameter logic [7:0] SEED        = 8'h3C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  logic              scl_q;
  logic              scl_prev;
  logic              sda_q;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic [7:0]        rd_data;
  logic              cnt_adv;
  logic              cnt_load;
  logic [MEM_AW-1:0] load_val;
  logic [MEM_AW-1:0] addr_cnt;
  logic              dev_hit;
  logic              addr_miss;

  i2c_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_q     (scl_q),
    .scl_prev  (scl_prev),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rd_fsm #(.AW(MEM_AW), .TGT_ADDR(TGT_ADDR)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .cnt_adv   (cnt_adv),
    .cnt_load  (cnt_load),
    .load_val  (load_val),
    .dev_hit   (dev_hit),
    .addr_miss (addr_miss)
  );

  i2c_rd_addr_ctr #(.AW(MEM_AW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (cnt_adv),
    .load     (cnt_load),
    .load_val (load_val),
    .cnt      (addr_cnt)
  );

  i2c_rd_rom #(.AW(MEM_AW), .SEED(SEED)) u_rom (
    .raddr (addr_cnt),
    .rdata (rd_data)
  );

endmodule

// File: rtl/i2c_rd_target_chk.sv
module i2c_rd_target_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_q,
  input logic          scl_prev,
  input logic          start_det,
  input logic          stop_det,
  input logic          sda_oe,
  input logic          cnt_adv,
  input logic          cnt_load,
  input logic [AW-1:0] addr_cnt,
  input logic          dev_hit,
  input logic          addr_miss
);

  AST_SDA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && scl_prev) |-> $stable(sda_oe)); // R11

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_det, stop_det})); // R2

  AST_HIT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    dev_hit |=> sda_oe); // R3

  AST_MISS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> !sda_oe); // R4

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R7

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_adv || cnt_load) |=> $stable(addr_cnt)); // R8

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_adv && !cnt_load && (&addr_cnt)) |=> (addr_cnt == '0)); // R9

endmodule

bind i2c_rd_target i2c_rd_target_chk #(.AW(MEM_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_q     (scl_q),
  .scl_prev  (scl_prev),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe),
  .cnt_adv   (cnt_adv),
  .cnt_load  (cnt_load),
  .addr_cnt  (addr_cnt),
  .dev_hit   (dev_hit),
  .addr_miss (addr_miss)
);

// File: tb/i2c_rd_target_tb.sv
module i2c_rd_target_tb;

  localparam int         AW    = 6;
  localparam int         DEPTH = 1 << AW;
  localparam logic [6:0] TGT   = 7'h50;
  localparam logic [7:0] SEED  = 8'h5A;
  localparam int         Q     = 10;

  // {random(1)/current(0), 16-bit address, byte count}
  localparam logic [24:0] VEC [8] = '{
    {1'b1, 16'h0005, 8'd3},
    {1'b0, 16'h0000, 8'd2},
    {1'b1, 16'h003E, 8'd4},
    {1'b0, 16'h0000, 8'd1},
    {1'b1, 16'hA57F, 8'd2},
    {1'b1, 16'h003F, 8'd1},
    {1'b0, 16'h0000, 8'd1},
    {1'b1, 16'h1234, 8'd5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  wire  sda_line = !(m_low || sda_oe);

  int n_chk = 0;
  int n_bad = 0;
  int mcnt = 0;
  int viol = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_rd_target #(.MEM_AW(AW), .TGT_ADDR(TGT), .SEED(SEED)) u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl),
    .sda_i  (sda_line),
    .sda_oe (sda_oe)
  );

  // R11 monitor: enable must not move while SCL stays high
  logic scl_last = 1'b1;
  logic oe_last = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && scl_last && (sda_oe !== oe_last)) viol++;
    scl_last = scl;
    oe_last  = sda_oe;
  end

  function automatic int exp_byte(input int a);
    return ((a * 29 + SEED) % 256) ^ ((a / 256) % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start;
    m_low = 1'b0; wq(Q);
    scl = 1'b1;   wq(Q);
    m_low = 1'b1; wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic do_stop;
    m_low = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    m_low = 1'b0; wq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_low = !b[i]; wq(Q);
      scl = 1'b1;    wq(Q);
      scl = 1'b0;    wq(Q);
    end
    m_low = 1'b0; wq(Q);
    scl = 1'b1;   wq(Q / 2);
    acked = !sda_line;
    wq(Q / 2);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic rd_byte(input bit ack, output logic [7:0] b);
    b = '0;
    m_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wq(Q);
      scl = 1'b1; wq(Q / 2);
      b = {b[6:0], sda_line};
      wq(Q / 2);
      scl = 1'b0;
    end
    m_low = ack; wq(Q);
    scl = 1'b1;  wq(Q);
    scl = 1'b0;
    m_low = 1'b0; wq(Q);
  endtask

  task automatic set_addr(input logic [15:0] ad);
    bit a;
    do_start;
    wr_byte({TGT, 1'b0}, a);  chk(a, "R5 write address ack", a, 1);
    wr_byte(ad[15:8], a);     chk(a, "R5 high byte ack", a, 1);
    wr_byte(ad[7:0], a);      chk(a, "R5 low byte ack", a, 1);
    mcnt = ad % DEPTH;
  endtask

  task automatic run_read(input int n, input bit rnd);
    bit a;
    logic [7:0] b;
    int e;
    do_start;
    wr_byte({TGT, 1'b1}, a);
    chk(a, "R2 R3 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i < n - 1, b);
      e = exp_byte(mcnt);
      if (i > 0 && mcnt == 0)   chk(b == e, "R9 wrapped byte", b, e);
      else if (i > 0)           chk(b == e, "R6 sequential byte", b, e);
      else if (rnd)             chk(b == e, "R5 random first byte", b, e);
      else                      chk(b == e, "R8 current first byte", b, e);
      mcnt = (mcnt + 1) % DEPTH;
    end
    do_stop;
    wq(4);
    chk(sda_oe == 1'b0, "R7 released after nack and stop", sda_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] b;
    wq(5);
    chk(sda_oe == 1'b0, "R1 enable in reset", sda_oe, 0);
    rst_n = 1'b1;
    wq(5);
    chk(sda_oe == 1'b0, "R1 enable after reset", sda_oe, 0);
    mcnt = 0;
    run_read(1, 1'b0);  // R1: location 0 first

    for (int v = 0; v < 8; v++) begin
      if (VEC[v][24]) begin
        set_addr(VEC[v][23:8]);
        run_read(int'(VEC[v][7:0]), 1'b1);
      end else begin
        run_read(int'(VEC[v][7:0]), 1'b0);
      end
    end

    // R4: wrong target, then clocks and a matching byte without START
    do_start;
    wr_byte({7'h23, 1'b1}, a);
    chk(!a, "R4 no ack for other target", a, 0);
    rd_byte(1'b0, b);
    chk(b == 8'hFF, "R4 line released after miss", b, 8'hFF);
    wr_byte({TGT, 1'b1}, a);
    chk(!a, "R4 no ack without START", a, 0);
    do_stop;
    run_read(2, 1'b0);  // counter untouched by ignored traffic

    // R10: data bytes after the address are acked and dropped
    set_addr(16'h0010);
    wr_byte(8'hAA, a);
    chk(a, "R10 data byte ack", a, 1);
    wr_byte(8'h55, a);
    chk(a, "R10 data byte ack", a, 1);
    do_stop;
    b = 8'(exp_byte(16'h0010));
    run_read(1, 1'b0);
    chk(mcnt == 16'h0011, "R10 counter kept loaded address", mcnt, 16'h0011);

    chk(viol == 0, "R11 enable stable while SCL high", viol, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule